// File: doc/BRIEF.md
# Character Blink Generator

This block makes a character cell flash on a text overlay. It counts vertical sync pulses in a free-running field counter. It decodes a 3-bit blink control code into a period length and an off-time share. On every pixel clock, it compares the count against the off-time limit to form a blink phase.

While the phase is off, a cell whose blink flag is set loses its foreground pixels. Cells without the flag, and every background pixel, pass through unchanged. The gated foreground bit goes to the colour stage downstream.

The control code has two fields. Bit 2 selects the period: 0 gives 64 fields and 1 gives 32 fields. Bits 1:0 give the off-time share: 00 turns blinking off, 01 gives a quarter of the period, 10 gives a half and 11 gives three quarters. The off share comes at the start of each period.

Top module: `char_blink_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the field counter clears to 0. With code 001 right after reset, `blink_off` is 1 because count 0 lies in the off window.
- R2: The field counter advances by one at the first clock edge where `vsync` is sampled high after being sampled low. A `vsync` held high over several edges counts once. The counter wraps from 63 to 0.
- R3: `blink_ctrl[2]` = 0 selects a 64-field period using all 6 counter bits. `blink_ctrl[2]` = 1 selects a 32-field period that compares only the low 5 counter bits.
- R4: `blink_ctrl[1:0]` = 00 disables blinking. `blink_off` stays 0 and every cell shows its foreground, whatever the period bit and the count.
- R5: With `blink_ctrl[1:0]` = d (1, 2 or 3), `blink_off` is 1 exactly while the compared count is below d × period / 4. That is 16/32/48 fields for a 64-field period and 8/16/24 for a 32-field period. `blink_off` follows a change of the code in the same cycle.
- R6: `fg_out` is 0 when `cell_blink` and `blink_off` are both 1; otherwise `fg_out` equals `fg_pixel`. It is combinational from the inputs and the phase.
- R7: A cell with `cell_blink` = 0 always passes `fg_pixel` to `fg_out`, in either phase.
- R8: `fg_out` is never 1 when `fg_pixel` is 0, so background pixels are never turned into foreground.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| vsync | input | 1 | Vertical sync level, counted on its rising edge |
| blink_ctrl | input | 3 | Bit 2 period select, bits 1:0 off-time share |
| cell_blink | input | 1 | Blink flag of the cell being drawn |
| fg_pixel | input | 1 | Foreground-on pixel of the cell |
| fg_out | output | 1 | Gated foreground pixel |
| blink_off | output | 1 | Current blink phase, 1 = foreground suppressed |

## Verification
The assertions check the following on every cycle:
- the counter steps by one after a detected sync edge and holds otherwise;
- the counter clears after reset;
- a disabled code keeps the phase on;
- the gate never creates foreground and leaves unflagged cells untouched.

Only the bench scenarios can show the off-window limits for each period and share. They cover the count just below and at each limit, the 32-field period ignoring the counter's top bit, and the wrap from 63 to 0. They also show that a long sync pulse advances the count only once, which appears as the phase at a chosen count.

// File: rtl/blink_pkg.sv
package blink_pkg;

    localparam int FIELD_CNT_W = 6;

    typedef enum logic [1:0] {
        DUTY_NONE = 2'b00,
        DUTY_QTR  = 2'b01,
        DUTY_HALF = 2'b10,
        DUTY_3QTR = 2'b11
    } duty_e;

    typedef struct packed {
        logic  short_period;
        duty_e duty;
    } blink_cfg_t;

    function automatic blink_cfg_t decode_ctrl(input logic [2:0] code);
        blink_cfg_t c;
        c.short_period = code[2];
        c.duty         = duty_e'(code[1:0]);
        return c;
    endfunction

endpackage

// File: rtl/blink_field_counter.sv
module blink_field_counter #(
    parameter int CNT_W = blink_pkg::FIELD_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vsync,
    output logic             vs_rise,
    output logic [CNT_W-1:0] count
);
    logic vs_q;

    assign vs_rise = vsync & ~vs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_q  <= 1'b0;
            count <= '0;
        end else begin
            vs_q <= vsync;
            if (vs_rise) begin
                count <= count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/blink_phase_cmp.sv
module blink_phase_cmp
    import blink_pkg::*;
#(
    parameter int CNT_W = FIELD_CNT_W
) (
    input  blink_cfg_t       cfg,
    input  logic [CNT_W-1:0] count,
    output logic             off
);
    localparam logic [CNT_W:0]   FULL_PER  = (CNT_W+1)'(1) << CNT_W;
    localparam logic [CNT_W:0]   SHORT_PER = (CNT_W+1)'(1) << (CNT_W-1);
    localparam logic [CNT_W-1:0] LOW_MASK  = {1'b0, {(CNT_W-1){1'b1}}};

    logic [CNT_W:0]   period;
    logic [CNT_W:0]   limit;
    logic [CNT_W-1:0] view;

    always_comb begin
        period = cfg.short_period ? SHORT_PER : FULL_PER;
        view   = cfg.short_period ? (count & LOW_MASK) : count;
        unique case (cfg.duty)
            DUTY_QTR:  limit = period >> 2;
            DUTY_HALF: limit = period >> 1;
            DUTY_3QTR: limit = (period >> 1) + (period >> 2);
            default:   limit = '0;
        endcase
        off = (cfg.duty != DUTY_NONE) && ({1'b0, view} < limit);
    end
endmodule

// File: rtl/blink_pixel_gate.sv
module blink_pixel_gate (
    input  logic off,
    input  logic cell_blink,
    input  logic fg_pixel,
    output logic fg_out
);
    always_comb begin
        fg_out = fg_pixel & ~(cell_blink & off);
    end
endmodule

// File: rtl/char_blink_gen.sv
module char_blink_gen
    import blink_pkg::*;
#(
    parameter int CNT_W = FIELD_CNT_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vsync,
    input  logic [2:0] blink_ctrl,
    input  logic       cell_blink,
    input  logic       fg_pixel,
    output logic       fg_out,
    output logic       blink_off
);
    logic [CNT_W-1:0] field_cnt;
    logic             vs_rise;
    blink_cfg_t       cfg;

    assign cfg = decode_ctrl(blink_ctrl);

    blink_field_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk     (clk),
        .rst     (rst),
        .vsync   (vsync),
        .vs_rise (vs_rise),
        .count   (field_cnt)
    );

    blink_phase_cmp #(.CNT_W(CNT_W)) cmp_i (
        .cfg   (cfg),
        .count (field_cnt),
        .off   (blink_off)
    );

    blink_pixel_gate gate_i (
        .off        (blink_off),
        .cell_blink (cell_blink),
        .fg_pixel   (fg_pixel),
        .fg_out     (fg_out)
    );
endmodule

// File: rtl/char_blink_chk.sv
module char_blink_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       blink_ctrl,
    input logic             cell_blink,
    input logic             fg_pixel,
    input logic             fg_out,
    input logic             blink_off,
    input logic             vs_rise,
    input logic [CNT_W-1:0] field_cnt
);
    assert_cnt_clear_R1: assert property (@(posedge clk)
        rst |=> field_cnt == '0);

    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (rst)
        vs_rise |=> field_cnt == CNT_W'($past(field_cnt) + 1'b1));

    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !vs_rise |=> $stable(field_cnt));

    assert_disabled_on_R4: assert property (@(posedge clk) disable iff (rst)
        blink_ctrl[1:0] == 2'b00 |-> !blink_off);

    assert_unflagged_pass_R7: assert property (@(posedge clk) disable iff (rst)
        !cell_blink |-> fg_out == fg_pixel);

    assert_no_new_fg_R8: assert property (@(posedge clk) disable iff (rst)
        !fg_pixel |-> !fg_out);
endmodule

bind char_blink_gen char_blink_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .blink_ctrl (blink_ctrl),
    .cell_blink (cell_blink),
    .fg_pixel   (fg_pixel),
    .fg_out     (fg_out),
    .blink_off  (blink_off),
    .vs_rise    (vs_rise),
    .field_cnt  (field_cnt)
);

// File: tb/char_blink_gen_tb.sv
`timescale 1ns/1ps
module char_blink_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vsync = 1'b0;
    logic [2:0] blink_ctrl = 3'b001;
    logic       cell_blink = 1'b0;
    logic       fg_pixel = 1'b0;
    logic       fg_out;
    logic       blink_off;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    char_blink_gen dut_i (
        .clk        (clk),
        .rst        (rst),
        .vsync      (vsync),
        .blink_ctrl (blink_ctrl),
        .cell_blink (cell_blink),
        .fg_pixel   (fg_pixel),
        .fg_out     (fg_out),
        .blink_off  (blink_off)
    );

    // {pulses[5:0], ctrl[2:0], cell_blink, fg_pixel, exp_off, exp_fg}
    localparam int NV = 14;
    localparam logic [12:0] VEC [NV] = '{
        {6'd0,  3'b001, 1'b1, 1'b1, 1'b1, 1'b0},  // cnt 0,  R5 R6
        {6'd15, 3'b001, 1'b1, 1'b1, 1'b1, 1'b0},  // cnt 15, R5
        {6'd1,  3'b001, 1'b1, 1'b1, 1'b0, 1'b1},  // cnt 16, R5 limit
        {6'd0,  3'b010, 1'b1, 1'b1, 1'b1, 1'b0},  // half, R5
        {6'd0,  3'b011, 1'b0, 1'b1, 1'b1, 1'b1},  // unflagged, R7
        {6'd31, 3'b011, 1'b1, 1'b1, 1'b1, 1'b0},  // cnt 47, R5
        {6'd1,  3'b011, 1'b1, 1'b1, 1'b0, 1'b1},  // cnt 48, R5 limit
        {6'd0,  3'b101, 1'b1, 1'b1, 1'b0, 1'b1},  // 32-field, low5=16, R3
        {6'd0,  3'b111, 1'b1, 1'b1, 1'b1, 1'b0},  // 32-field 3/4, R3
        {6'd0,  3'b000, 1'b1, 1'b1, 1'b0, 1'b1},  // disabled, R4
        {6'd0,  3'b100, 1'b1, 1'b1, 1'b0, 1'b1},  // disabled short, R4
        {6'd16, 3'b001, 1'b1, 1'b0, 1'b1, 1'b0},  // wrap to 0, R2 R8
        {6'd8,  3'b101, 1'b1, 1'b1, 1'b0, 1'b1},  // cnt 8, R3 limit
        {6'd0,  3'b110, 1'b1, 1'b1, 1'b1, 1'b0}   // cnt 8 half short, R5
    };

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) vsync = 1'b1;
            @(negedge clk) vsync = 1'b0;
        end
    endtask

    task automatic check(input string req, input logic exp_off, input logic exp_fg);
        #1;
        n_run++;
        if (blink_off !== exp_off || fg_out !== exp_fg) begin
            n_fail++;
            $display("FAIL %s: blink_off=%b fg_out=%b expected blink_off=%b fg_out=%b",
                     req, blink_off, fg_out, exp_off, exp_fg);
        end
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cell_blink = 1'b1;
        fg_pixel = 1'b1;
        check("R1 reset phase", 1'b1, 1'b0);

        for (int v = 0; v < NV; v++) begin
            pulse(int'(VEC[v][12:7]));
            @(negedge clk);
            blink_ctrl = VEC[v][6:4];
            cell_blink = VEC[v][3];
            fg_pixel   = VEC[v][2];
            check($sformatf("R5 vector %0d", v), VEC[v][1], VEC[v][0]);
        end

        // count 8 -> 18, then a mid-run reset returns the phase to off (R1)
        pulse(10);
        @(negedge clk);
        blink_ctrl = 3'b001;
        cell_blink = 1'b1;
        fg_pixel = 1'b1;
        check("R1 before reset cnt 18", 1'b0, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
        check("R1 after reset cnt 0", 1'b1, 1'b0);

        // long sync pulse counts once (R2)
        blink_ctrl = 3'b101;
        pulse(6);
        @(negedge clk) vsync = 1'b1;
        repeat (4) @(negedge clk);
        vsync = 1'b0;
        @(negedge clk);
        check("R2 long pulse cnt 7", 1'b1, 1'b0);
        pulse(1);
        @(negedge clk);
        check("R2 cnt 8", 1'b0, 1'b1);

        // phase off, unflagged cell and background pixel (R7 R8 R6)
        blink_ctrl = 3'b110;
        cell_blink = 1'b0;
        check("R7 unflagged in off phase", 1'b1, 1'b1);
        fg_pixel = 1'b0;
        check("R8 background in off phase", 1'b1, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule